// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Shared Term Steering

This block is a configurable two-level logic plane. A bus of logic inputs is expanded into true and inverted literals. Each of a set of product terms is the AND of any chosen literals. A steering matrix then ORs any subset of those product terms into each of sixteen sum outputs. A term is not tied to one output: the same term may drive several sums at once, and each sum may take anywhere from zero to sixteen terms. The sums are purely combinational and feed downstream macrocells.

All programming is held in one configuration image. The image is shifted in one bit per clock through a serial data/clock/enable interface before operation. While the enable is high the sum outputs are forced low. When the enable drops, the loaded image is audited. If any sum has more terms steered to it than the allowed maximum, the image is rejected: an error flag rises and all sums stay low until a legal image is loaded.

Top module: `sop_steer_array`

## Requirements
- R1: After synchronous active-low reset, every sum output is 0 and `cfg_err` is 0, whatever the value of `lit_in`.
- R2: A product term is the AND of the literals whose fuses are set. In each term's fuse word, bit 2*i selects `lit_in[i]` and bit 2*i+1 selects its inverse.
- R3: A product term with no fuse set evaluates to 1.
- R4: A product term that selects both the true and the inverted literal of the same input is always 0.
- R5: Steering bit (s, p) set means term p is ORed into sum s. A sum with no steering bit set is 0.
- R6: One product term steered to several sums drives all of them at the same time.
- R7: A sum with exactly 16 steered terms is accepted. It ORs all 16 terms and leaves `cfg_err` at 0.
- R8: If any sum has more than 16 steered terms when the enable falls, the image is not applied. `cfg_err` becomes 1 and all sums stay 0. The next legal load clears `cfg_err` and applies that image.
- R9: While `cfg_en` is 1, every sum output is 0.
- R10: The image is 7568 bits long and is shifted MSB-first, one bit per clock while `cfg_en` is 1. Image bit `1376 + 72*p + b` is fuse bit b of term p. Image bit `86*s + p` is steering bit (s, p). The image is committed on the first clock edge at which `cfg_en` is 0 after having been 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shifting and commit |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable; sums forced to 0 while high |
| cfg_din | input | 1 | Serial configuration data, MSB of the image first |
| lit_in | input | 36 | Logic inputs to the array |
| sum_o | output | 16 | Combinational sum-of-products outputs |
| cfg_err | output | 1 | Set when the last committed image over-subscribed a sum |

## Verification
The bench places single set bits at both ends of the image, so a load that reverses the bit order or skips a bit shows up as a wrong or missing sum. Empty and self-contradicting terms are checked against their constant values: a design that defaulted empty terms to 0 would lose one sum, and one that ignored the inverted literal would let a contradiction pass. The term-count limit is probed at exactly 16 terms (must work) and at 17 (must be rejected with all sums low). An off-by-one in the audit would either reject the legal case or light the outputs in the illegal one. Outputs are also sampled in the middle of a load over a live configuration, to catch any leakage while shifting.

// File: rtl/sop_pkg.sv
// sop_pkg: default dimensions and shared types for the sum-of-products array.
// Assumes all modules take these values as parameter defaults.
package sop_pkg;
    localparam int DEF_N_IN      = 36;
    localparam int DEF_N_PT      = 86;
    localparam int DEF_N_SUM     = 16;
    localparam int DEF_MAX_TERMS = 16;

    // Configuration phase as seen by the commit logic.
    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_LOAD = 1'b1
    } cfg_phase_e;
endpackage

// File: rtl/sop_cfg_chain.sv
// sop_cfg_chain: holds the whole configuration image as one serial chain.
// Bits enter at image bit 0 and move upward, so an MSB-first stream of
// TOTAL bits lands with its first bit at the top. Fuse words sit above the
// steering rows. Assumes the caller shifts exactly TOTAL bits per load.
module sop_cfg_chain #(
    parameter int N_IN  = sop_pkg::DEF_N_IN,
    parameter int N_PT  = sop_pkg::DEF_N_PT,
    parameter int N_SUM = sop_pkg::DEF_N_SUM
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               shift_en,
    input  logic                               din,
    output logic [N_PT-1:0][2*N_IN-1:0]        fuse,
    output logic [N_SUM-1:0][N_PT-1:0]         steer
);
    localparam int LIT_W      = 2 * N_IN;
    localparam int STEER_BITS = N_SUM * N_PT;
    localparam int FUSE_BITS  = N_PT * LIT_W;
    localparam int TOTAL      = STEER_BITS + FUSE_BITS;

    logic [TOTAL-1:0] chain_q;

    // Shift one configuration bit per clock while loading.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (shift_en)
            chain_q <= {chain_q[TOTAL-2:0], din};
    end

    assign steer = chain_q[STEER_BITS-1:0];
    assign fuse  = chain_q[TOTAL-1:STEER_BITS];
endmodule

// File: rtl/sop_term_array.sv
// sop_term_array: expands inputs into interleaved true/inverted literals and
// forms one AND per product term over the literals whose fuse is set.
// Assumes fuse bit 2*i picks input i and bit 2*i+1 picks its inverse.
module sop_term_array #(
    parameter int N_IN = sop_pkg::DEF_N_IN,
    parameter int N_PT = sop_pkg::DEF_N_PT
) (
    input  logic [N_IN-1:0]                lit_in,
    input  logic [N_PT-1:0][2*N_IN-1:0]    fuse,
    output logic [N_PT-1:0]                term
);
    localparam int LIT_W = 2 * N_IN;

    logic [LIT_W-1:0] cols;

    // Build the literal columns in both polarities.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            cols[2*i]   = lit_in[i];
            cols[2*i+1] = ~lit_in[i];
        end
    end

    // One wide AND per term; an unfused column is treated as a 1.
    for (genvar p = 0; p < N_PT; p++) begin : g_term
        assign term[p] = &(cols | ~fuse[p]);
    end
endmodule

// File: rtl/sop_sum_router.sv
// sop_sum_router: ORs the steered product terms into each sum output.
// Any term may feed any number of sums. All sums are forced to 0 when
// out_en is low. Assumes steer[s][p] = 1 connects term p to sum s.
module sop_sum_router #(
    parameter int N_PT  = sop_pkg::DEF_N_PT,
    parameter int N_SUM = sop_pkg::DEF_N_SUM
) (
    input  logic [N_PT-1:0]                term,
    input  logic [N_SUM-1:0][N_PT-1:0]     steer,
    input  logic                           out_en,
    output logic [N_SUM-1:0]               sum
);
    // One masked OR-reduction per sum.
    for (genvar s = 0; s < N_SUM; s++) begin : g_sum
        assign sum[s] = out_en & (|(term & steer[s]));
    end
endmodule

// File: rtl/sop_steer_audit.sv
// sop_steer_audit: counts the terms steered to each sum and flags the image
// as legal only when no sum exceeds MAX_TERMS. Purely combinational; the
// top samples the result at commit.
module sop_steer_audit #(
    parameter int N_PT      = sop_pkg::DEF_N_PT,
    parameter int N_SUM     = sop_pkg::DEF_N_SUM,
    parameter int MAX_TERMS = sop_pkg::DEF_MAX_TERMS
) (
    input  logic [N_SUM-1:0][N_PT-1:0]     steer,
    output logic                           legal
);
    localparam int CNT_W = $clog2(N_PT + 1);

    logic [N_SUM-1:0] over;

    for (genvar s = 0; s < N_SUM; s++) begin : g_cnt
        logic [CNT_W-1:0] acc;
        // Population count of one steering row.
        always_comb begin
            acc = '0;
            for (int p = 0; p < N_PT; p++)
                acc = acc + CNT_W'(steer[s][p]);
        end
        assign over[s] = (acc > CNT_W'(MAX_TERMS));
    end

    assign legal = ~|over;
endmodule

// File: rtl/sop_steer_array.sv
// sop_steer_array: programmable AND-OR plane with shared term steering.
// A serial image loads while cfg_en is high (sums held at 0). On the first
// clock with cfg_en low the image is audited: legal images arm the outputs;
// over-subscribed ones raise cfg_err and leave the outputs disarmed.
// Assumes cfg_en is held for exactly the image length per load.
module sop_steer_array #(
    parameter int N_IN      = sop_pkg::DEF_N_IN,
    parameter int N_PT      = sop_pkg::DEF_N_PT,
    parameter int N_SUM     = sop_pkg::DEF_N_SUM,
    parameter int MAX_TERMS = sop_pkg::DEF_MAX_TERMS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic [N_IN-1:0]   lit_in,
    output logic [N_SUM-1:0]  sum_o,
    output logic              cfg_err
);
    import sop_pkg::*;

    logic [N_PT-1:0][2*N_IN-1:0] fuse_q;
    logic [N_SUM-1:0][N_PT-1:0]  steer_q;
    logic [N_PT-1:0]             term;
    logic                        audit_ok;
    logic                        armed_q;
    logic                        commit;
    logic                        out_en;
    cfg_phase_e                  phase_q;

    sop_cfg_chain #(.N_IN(N_IN), .N_PT(N_PT), .N_SUM(N_SUM)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .fuse     (fuse_q),
        .steer    (steer_q)
    );

    sop_term_array #(.N_IN(N_IN), .N_PT(N_PT)) u_terms (
        .lit_in (lit_in),
        .fuse   (fuse_q),
        .term   (term)
    );

    sop_steer_audit #(.N_PT(N_PT), .N_SUM(N_SUM), .MAX_TERMS(MAX_TERMS)) u_audit (
        .steer (steer_q),
        .legal (audit_ok)
    );

    sop_sum_router #(.N_PT(N_PT), .N_SUM(N_SUM)) u_router (
        .term   (term),
        .steer  (steer_q),
        .out_en (out_en),
        .sum    (sum_o)
    );

    // Track whether the previous cycle was a load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_RUN;
        else
            phase_q <= cfg_en ? PH_LOAD : PH_RUN;
    end

    assign commit = (phase_q == PH_LOAD) && !cfg_en;

    // Arm the outputs or flag an error when a load completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cfg_err <= 1'b0;
        end else if (cfg_en) begin
            armed_q <= 1'b0;
        end else if (commit) begin
            armed_q <= audit_ok;
            cfg_err <= !audit_ok;
        end
    end

    assign out_en = armed_q & ~cfg_en;
endmodule

// File: rtl/sop_steer_array_chk.sv
// sop_steer_array_chk: temporal checks on the sum-of-products array,
// attached to every instance of the top through bind.
module sop_steer_array_chk #(
    parameter int N_PT      = sop_pkg::DEF_N_PT,
    parameter int N_SUM     = sop_pkg::DEF_N_SUM,
    parameter int MAX_TERMS = sop_pkg::DEF_MAX_TERMS
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_en,
    input logic [N_SUM-1:0]              sum_o,
    input logic                          cfg_err,
    input logic [N_SUM-1:0][N_PT-1:0]    steer_q
);
    logic any_over;

    // Independent count of over-subscribed rows.
    always_comb begin
        any_over = 1'b0;
        for (int s = 0; s < N_SUM; s++)
            if ($countones(steer_q[s]) > MAX_TERMS)
                any_over = 1'b1;
    end

    // R9
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (sum_o == '0));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (sum_o == '0));

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !cfg_en && !$past(cfg_en)) |-> any_over);

    // R8
    err_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_err) |-> $past(cfg_en, 2));

    // R7
    legal_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_o != '0) |-> !any_over);

    for (genvar s = 0; s < N_SUM; s++) begin : g_empty
        // R5
        empty_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (steer_q[s] == '0) |-> !sum_o[s]);
    end
endmodule

bind sop_steer_array sop_steer_array_chk #(
    .N_PT(N_PT), .N_SUM(N_SUM), .MAX_TERMS(MAX_TERMS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .sum_o   (sum_o),
    .cfg_err (cfg_err),
    .steer_q (steer_q)
);

// File: tb/sop_steer_array_bench.sv
`timescale 1ns/1ps
module sop_steer_array_bench;
    localparam int N_IN       = 36;
    localparam int N_PT       = 86;
    localparam int N_SUM      = 16;
    localparam int LIT_W      = 2 * N_IN;
    localparam int STEER_BITS = N_SUM * N_PT;
    localparam int TOTAL      = STEER_BITS + N_PT * LIT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_en = 1'b0;
    logic              cfg_din = 1'b0;
    logic [N_IN-1:0]   lit_in = '0;
    logic [N_SUM-1:0]  sum_o;
    logic              cfg_err;

    int checks = 0;
    int errors = 0;

    logic [LIT_W-1:0] bf [N_PT];
    logic [N_PT-1:0]  bs [N_SUM];

    sop_steer_array u_sop_steer_array (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .lit_in(lit_in), .sum_o(sum_o), .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic img_bit(input int k);
        if (k >= STEER_BITS)
            return bf[(k - STEER_BITS) / LIT_W][(k - STEER_BITS) % LIT_W];
        return bs[k / N_PT][k % N_PT];
    endfunction

    task automatic clear_image();
        for (int p = 0; p < N_PT; p++) bf[p] = '0;
        for (int s = 0; s < N_SUM; s++) bs[s] = '0;
    endtask

    // Stream the image MSB-first; optionally sample outputs mid-load (R9).
    task automatic load_image(input bit probe_mid);
        @(negedge clk);
        for (int k = TOTAL - 1; k >= 0; k--) begin
            cfg_en  = 1'b1;
            cfg_din = img_bit(k);
            if (probe_mid && k == TOTAL / 2) begin
                #1 chk("R9 sums low while loading", 32'(sum_o), 32'h0);
            end
            @(negedge clk);
        end
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
        @(negedge clk);
    endtask

    task automatic apply(input logic [N_IN-1:0] x);
        lit_in = x;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset(input string tag);
        apply('1);
        chk({tag, " R1 sums after reset"}, 32'(sum_o), 32'h0);
        chk({tag, " R1 cfg_err after reset"}, 32'(cfg_err), 32'h0);
    endtask

    task automatic t_literals();
        clear_image();
        bf[0][0] = 1'b1;  bf[0][3] = 1'b1;                    // x0 & ~x1
        bs[0][0] = 1'b1;  bs[3][0] = 1'b1;
        bs[1][1] = 1'b1;                                      // empty term 1
        bf[2][10] = 1'b1; bf[2][12] = 1'b1; bf[2][71] = 1'b1; // x5 & x6 & ~x35
        bs[2][2] = 1'b1;  bs[3][2] = 1'b1;
        bf[3][8] = 1'b1;  bf[3][9] = 1'b1;                    // x4 & ~x4
        bs[4][3] = 1'b1;
        bf[85][71] = 1'b1; bs[15][85] = 1'b1;                 // ~x35, top of image
        load_image(1'b0);
        chk("R8 no error on legal image", 32'(cfg_err), 32'h0);
        apply(36'h0);
        chk("R3 R10 R5 idle pattern", 32'(sum_o), 32'h8002);
        apply(36'h1);
        chk("R2 R6 R10 x0 and not x1", 32'(sum_o), 32'h800B);
        apply(36'h60);
        chk("R2 R6 x5 and x6 shared term", 32'(sum_o), 32'h800E);
        apply(36'h8_0000_0063);
        chk("R2 inverted literal kills terms", 32'(sum_o), 32'h0002);
        apply(36'h10);
        chk("R4 contradiction with x4 high", 32'(sum_o[4]), 32'h0);
        apply('1);
        chk("R4 R5 all ones", 32'(sum_o), 32'h0002);
    endtask

    task automatic build_sixteen();
        clear_image();
        for (int p = 10; p < 26; p++) begin
            bf[p][2*(p-10)] = 1'b1;
            bs[7][p] = 1'b1;
            bs[8][p] = 1'b1;
        end
    endtask

    task automatic t_boundary();
        build_sixteen();
        apply(36'h1);
        load_image(1'b1);
        chk("R7 sixteen terms accepted", 32'(cfg_err), 32'h0);
        apply(36'h0);
        chk("R7 no input high", 32'(sum_o), 32'h0);
        apply(36'h1 << 15);
        chk("R7 sixteenth term reaches sums", 32'(sum_o), 32'h0180);
        apply(36'h1 << 16);
        chk("R7 unassigned input", 32'(sum_o), 32'h0);
    endtask

    task automatic t_overflow();
        build_sixteen();
        bf[26][32] = 1'b1;
        bs[7][26]  = 1'b1;
        apply(36'h1 << 15);
        load_image(1'b1);
        chk("R8 seventeen terms flag error", 32'(cfg_err), 32'h1);
        chk("R8 rejected image drives nothing", 32'(sum_o), 32'h0);
        apply('1);
        chk("R8 rejected image all ones", 32'(sum_o), 32'h0);
    endtask

    task automatic t_recover();
        build_sixteen();
        load_image(1'b0);
        chk("R8 legal reload clears error", 32'(cfg_err), 32'h0);
        apply(36'h1 << 3);
        chk("R8 legal reload applied", 32'(sum_o), 32'h0180);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_reset("initial");
        t_literals();
        t_boundary();
        t_overflow();
        t_recover();
        do_reset();
        t_reset("after load");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule